// File: doc/BRIEF.md
# Hierarchical Page Table Walker

This block translates one virtual address at a time by walking a radix page table held in memory, with eight-byte entries. On a start pulse it captures the virtual address, the root table register, the paging mode (four levels, or three levels for an extended physical address space), the no-execute enable, the access type and the privilege of the access. It then issues entry reads one by one on a simple request/acknowledge memory port.

At each level it checks the entry for faults and sets the accessed flag by writing the entry back when needed. It also narrows the write and user rights. The walk ends either at a leaf, which is a 4 KB page or a 2 MB large page found at the directory level, or at a fault. The result is given as a one-cycle done pulse together with either the translation attributes or the fault details.

A translation cache or a core's memory unit drives it with a miss and takes the result on the done pulse. Memory traffic is strictly serial: one request stays outstanding until it is acknowledged.

Top module: `pt_walker`

## Requirements
- R1: In four-level mode (long_mode_i=1) the first read goes to {root_i[51:12], 12'b0} + vaddr_i[47:39]*8. The levels visited are, in order, top, pointer, directory, table.
- R2: After a present, non-faulting, non-leaf entry, the next read address is {entry[51:12], 12'b0} + index*8. The index is vaddr bits 38:30 after the top level, 29:21 after the pointer level, and 20:12 after the directory level.
- R3: mem_uc_o on the first read equals root_i[4]. On every later read it equals bit 4 of the entry read just before. A writeback carries the same mem_uc_o as the read of that entry.
- R4: An entry that is present, causes no fault and has accessed bit 5 clear is written back once to its own address with bit 5 set, and no other bit changes. The writeback comes right after its read and before any further access. This never applies to the three-level pointer entry, and no write occurs otherwise.
- R5: The writable (entry bit 1) and user (bit 2) results are loaded from the first rights-bearing level and ANDed with the same bits of every lower level that is visited.
- R6: An entry with present bit 0 clear ends the walk with fault_o=1 and fault_present_o=0. No further access follows.
- R7: An entry with bit 63 set, when nx_en_i=1 and acc_i is execute (2'd2), ends the walk with fault_o=1 and fault_present_o=1. No writeback of that entry takes place.
- R8: A present directory entry with page-size bit 7 set ends the walk with page_2m_o=1, pa_o={entry[51:21], 21'b0} and pat_o=entry[12].
- R9: A leaf table entry gives page_2m_o=0 and pa_o={entry[51:12], 12'b0}. pat_o is entry bit 12 in four-level mode and entry bit 7 in three-level mode.
- R10: In three-level mode (long_mode_i=0) the first read goes to {root_i[51:5], 5'b0} + vaddr_i[31:30]*8. That pointer entry is checked for presence only. The directory level then loads the rights afresh, and the next index is vaddr bits 29:21.
- R11: On a fault, fault_user_o repeats user_i and fault_acc_o repeats acc_i (read 0, write 1, execute 2). The exception is an execute access with nx_en_i=0, which is reported as read.
- R12: On success, global_o and uncache_o are leaf entry bits 8 and 4, and nx_o is the OR of bit 63 of every rights-bearing entry visited.
- R13: After reset the port is idle. done_o is high for exactly one cycle, in the cycle after the acknowledgement of the walk's last access.
- R14: All inputs are captured on the start pulse. A start_i pulse or an input change during a walk has no effect on that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a walk (taken only when idle) |
| long_mode_i | input | 1 | 1: four-level mode, 0: three-level mode |
| nx_en_i | input | 1 | No-execute checking enable |
| acc_i | input | 2 | Access type: 0 read, 1 write, 2 execute |
| user_i | input | 1 | Access made at user privilege |
| vaddr_i | input | 48 | Virtual address |
| root_i | input | 52 | Root table register (base and cache-disable bit 4) |
| busy_o | output | 1 | Walk in progress |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Request is an entry writeback |
| mem_addr_o | output | 52 | Entry address |
| mem_uc_o | output | 1 | Request is uncacheable |
| mem_wdata_o | output | 64 | Writeback data |
| mem_ack_i | input | 1 | Request acknowledged (read data valid) |
| mem_rdata_i | input | 64 | Entry read data |
| done_o | output | 1 | Result valid for one cycle |
| fault_o | output | 1 | Walk ended in a fault |
| fault_present_o | output | 1 | Present bit of the faulting entry |
| fault_user_o | output | 1 | Faulting access was a user access |
| fault_acc_o | output | 2 | Reported access type of the fault |
| pa_o | output | 52 | Physical page base |
| page_2m_o | output | 1 | Result is a 2 MB page |
| writable_o | output | 1 | Accumulated write right |
| user_o | output | 1 | Accumulated user right |
| global_o | output | 1 | Leaf global bit |
| uncache_o | output | 1 | Leaf cache-disable bit |
| pat_o | output | 1 | Leaf attribute-table bit |
| nx_o | output | 1 | Accumulated no-execute |

## Verification
Two functions can be triggered by the same acknowledged read: the accessed-flag writeback and the end of the walk. This happens when the entry is a leaf, or when it faults with its accessed bit clear. The bench sets up leaf and 2 MB entries with bit 5 clear, and a no-execute fault on an entry whose bit 5 is also clear. A reference walk predicts the exact access stream. Each request is compared with that stream as it is acknowledged. For a leaf, the bench requires done to follow the writeback's acknowledgement and not the read's. For a fault, it requires that no write appears at all.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int ENT_W   = 64;
  localparam int IDX_W   = 9;
  localparam int PG_SH   = 12;
  localparam int BIG_SH  = 21;
  localparam int ESZ_SH  = 3;
  localparam int TOP3_W  = 2;
  localparam int TOP3_LSB = PG_SH + 2 * IDX_W;
  localparam int R3_SH   = ESZ_SH + TOP3_W;

  localparam int B_P     = 0;
  localparam int B_W     = 1;
  localparam int B_U     = 2;
  localparam int B_PCD   = 4;
  localparam int B_A     = 5;
  localparam int B_PS    = 7;
  localparam int B_G     = 8;
  localparam int B_PAT_L = 7;
  localparam int B_PAT_H = 12;
  localparam int B_NX    = 63;

  typedef enum logic [2:0] {LV_PTR, LV_L4, LV_L3, LV_L2, LV_L1} level_e;
  typedef enum logic [1:0] {ACC_RD = 2'd0, ACC_WR = 2'd1, ACC_EX = 2'd2} acc_e;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WB, ST_FIN} state_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
#(
  parameter int PA_W = 52,
  parameter int VA_W = 48
) (
  input  logic [VA_W-1:0]  start_va_i,
  input  logic [PA_W-1:0]  root_i,
  input  logic             long_i,
  input  logic [VA_W-1:0]  walk_va_i,
  input  level_e           lvl_i,
  input  logic [ENT_W-1:0] ent_i,
  output logic [PA_W-1:0]  first_addr_o,
  output logic [PA_W-1:0]  next_addr_o,
  output level_e           next_lvl_o
);
  localparam int LEVELS = (VA_W - PG_SH) / IDX_W;

  logic [IDX_W-1:0] walk_idx [LEVELS];
  logic [IDX_W-1:0] nxt_idx;
  logic [IDX_W-1:0] start_top_idx;

  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign walk_idx[g] = walk_va_i[PG_SH + g*IDX_W +: IDX_W];
  end

  assign start_top_idx = start_va_i[PG_SH + (LEVELS-1)*IDX_W +: IDX_W];

  always_comb begin
    unique case (lvl_i)
      LV_L4:   begin next_lvl_o = LV_L3; nxt_idx = walk_idx[2]; end
      LV_L3:   begin next_lvl_o = LV_L2; nxt_idx = walk_idx[1]; end
      LV_PTR:  begin next_lvl_o = LV_L2; nxt_idx = walk_idx[1]; end
      default: begin next_lvl_o = LV_L1; nxt_idx = walk_idx[0]; end
    endcase
  end

  assign next_addr_o = {ent_i[PA_W-1:PG_SH], nxt_idx, {ESZ_SH{1'b0}}};

  // four-level root is page aligned, three-level root is 32-byte aligned
  assign first_addr_o = long_i
    ? {root_i[PA_W-1:PG_SH], start_top_idx, {ESZ_SH{1'b0}}}
    : {root_i[PA_W-1:R3_SH], start_va_i[TOP3_LSB +: TOP3_W], {ESZ_SH{1'b0}}};

  logic unused_bits;
  assign unused_bits = ^{start_va_i, walk_va_i, root_i, ent_i, walk_idx[LEVELS-1]};
endmodule

// File: rtl/ptw_entry_eval.sv
module ptw_entry_eval
  import ptw_pkg::*;
#(
  parameter int PA_W = 52
) (
  input  level_e           lvl_i,
  input  logic             long_i,
  input  logic             nx_en_i,
  input  acc_e             acc_i,
  input  logic [ENT_W-1:0] ent_i,
  output logic             fault_o,
  output logic             leaf_o,
  output logic             big_o,
  output logic             wb_o,
  output logic             top_o,
  output logic             pat_o,
  output logic [PA_W-1:0]  base_o,
  output logic [ENT_W-1:0] wb_data_o
);
  logic is_ptr, nx_hit;

  assign is_ptr  = (lvl_i == LV_PTR);
  assign nx_hit  = ent_i[B_NX] & nx_en_i & (acc_i == ACC_EX) & ~is_ptr;
  assign fault_o = ~ent_i[B_P] | nx_hit;
  assign big_o   = (lvl_i == LV_L2) & ent_i[B_PS];
  assign leaf_o  = ~fault_o & ((lvl_i == LV_L1) | big_o);
  assign wb_o    = ~fault_o & ~is_ptr & ~ent_i[B_A];
  assign top_o   = long_i ? (lvl_i == LV_L4) : (lvl_i == LV_L2);
  assign pat_o   = (big_o | long_i) ? ent_i[B_PAT_H] : ent_i[B_PAT_L];

  assign base_o = big_o ? {ent_i[PA_W-1:BIG_SH], {BIG_SH{1'b0}}}
                        : {ent_i[PA_W-1:PG_SH], {PG_SH{1'b0}}};

  always_comb begin
    wb_data_o      = ent_i;
    wb_data_o[B_A] = 1'b1;
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int PA_W = 52,
  parameter int VA_W = 48
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            long_mode_i,
  input  logic            nx_en_i,
  input  logic [1:0]      acc_i,
  input  logic            user_i,
  input  logic [VA_W-1:0] vaddr_i,
  input  logic [PA_W-1:0] root_i,
  output logic            busy_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [PA_W-1:0] mem_addr_o,
  output logic            mem_uc_o,
  output logic [63:0]     mem_wdata_o,
  input  logic            mem_ack_i,
  input  logic [63:0]     mem_rdata_i,
  output logic            done_o,
  output logic            fault_o,
  output logic            fault_present_o,
  output logic            fault_user_o,
  output logic [1:0]      fault_acc_o,
  output logic [PA_W-1:0] pa_o,
  output logic            page_2m_o,
  output logic            writable_o,
  output logic            user_o,
  output logic            global_o,
  output logic            uncache_o,
  output logic            pat_o,
  output logic            nx_o
);
  state_e           state_q;
  level_e           lvl_q, nx_lvl_q;
  logic             long_q, nx_en_q, user_q;
  acc_e             acc_q;
  logic [VA_W-1:0]  va_q;
  logic [PA_W-1:0]  addr_q, nx_addr_q;
  logic             uc_q, nx_uc_q, fin_after_wb_q;
  logic [ENT_W-1:0] wdata_q;
  logic             wr_q, us_q, nx_q, fault_q, fpres_q;
  logic [PA_W-1:0]  pa_q;
  logic             big_q, glb_q, ruc_q, pat_q;

  logic [PA_W-1:0]  first_addr, next_addr;
  level_e           next_lvl;
  logic             ev_fault, ev_leaf, ev_big, ev_wb, ev_top, ev_pat;
  logic [PA_W-1:0]  ev_base;
  logic [ENT_W-1:0] ev_wb_data;

  ptw_addr_gen #(.PA_W(PA_W), .VA_W(VA_W)) u_addr (
    .start_va_i  (vaddr_i),
    .root_i      (root_i),
    .long_i      (long_mode_i),
    .walk_va_i   (va_q),
    .lvl_i       (lvl_q),
    .ent_i       (mem_rdata_i),
    .first_addr_o(first_addr),
    .next_addr_o (next_addr),
    .next_lvl_o  (next_lvl)
  );

  ptw_entry_eval #(.PA_W(PA_W)) u_eval (
    .lvl_i    (lvl_q),
    .long_i   (long_q),
    .nx_en_i  (nx_en_q),
    .acc_i    (acc_q),
    .ent_i    (mem_rdata_i),
    .fault_o  (ev_fault),
    .leaf_o   (ev_leaf),
    .big_o    (ev_big),
    .wb_o     (ev_wb),
    .top_o    (ev_top),
    .pat_o    (ev_pat),
    .base_o   (ev_base),
    .wb_data_o(ev_wb_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= ST_IDLE;
      lvl_q          <= LV_L4;
      nx_lvl_q       <= LV_L4;
      long_q         <= 1'b0;
      nx_en_q        <= 1'b0;
      user_q         <= 1'b0;
      acc_q          <= ACC_RD;
      va_q           <= '0;
      addr_q         <= '0;
      nx_addr_q      <= '0;
      uc_q           <= 1'b0;
      nx_uc_q        <= 1'b0;
      fin_after_wb_q <= 1'b0;
      wdata_q        <= '0;
      wr_q           <= 1'b0;
      us_q           <= 1'b0;
      nx_q           <= 1'b0;
      fault_q        <= 1'b0;
      fpres_q        <= 1'b0;
      pa_q           <= '0;
      big_q          <= 1'b0;
      glb_q          <= 1'b0;
      ruc_q          <= 1'b0;
      pat_q          <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          long_q  <= long_mode_i;
          nx_en_q <= nx_en_i;
          user_q  <= user_i;
          acc_q   <= acc_e'(acc_i);
          va_q    <= vaddr_i;
          addr_q  <= first_addr;
          uc_q    <= root_i[B_PCD];
          lvl_q   <= long_mode_i ? LV_L4 : LV_PTR;
          fault_q <= 1'b0;
          fpres_q <= 1'b0;
          wr_q    <= 1'b0;
          us_q    <= 1'b0;
          nx_q    <= 1'b0;
          pa_q    <= '0;
          big_q   <= 1'b0;
          glb_q   <= 1'b0;
          ruc_q   <= 1'b0;
          pat_q   <= 1'b0;
          state_q <= ST_RD;
        end
        ST_RD: if (mem_ack_i) begin
          if (ev_fault) begin
            fault_q <= 1'b1;
            fpres_q <= mem_rdata_i[B_P];
            state_q <= ST_FIN;
          end else begin
            if (lvl_q != LV_PTR) begin
              wr_q <= ev_top ? mem_rdata_i[B_W]  : (wr_q & mem_rdata_i[B_W]);
              us_q <= ev_top ? mem_rdata_i[B_U]  : (us_q & mem_rdata_i[B_U]);
              nx_q <= ev_top ? mem_rdata_i[B_NX] : (nx_q | mem_rdata_i[B_NX]);
            end
            if (ev_leaf) begin
              pa_q  <= ev_base;
              big_q <= ev_big;
              glb_q <= mem_rdata_i[B_G];
              ruc_q <= mem_rdata_i[B_PCD];
              pat_q <= ev_pat;
            end
            nx_addr_q      <= next_addr;
            nx_lvl_q       <= next_lvl;
            nx_uc_q        <= mem_rdata_i[B_PCD];
            fin_after_wb_q <= ev_leaf;
            if (ev_wb) begin
              wdata_q <= ev_wb_data;
              state_q <= ST_WB;
            end else if (ev_leaf) begin
              state_q <= ST_FIN;
            end else begin
              addr_q <= next_addr;
              lvl_q  <= next_lvl;
              uc_q   <= mem_rdata_i[B_PCD];
            end
          end
        end
        ST_WB: if (mem_ack_i) begin
          if (fin_after_wb_q) begin
            state_q <= ST_FIN;
          end else begin
            addr_q  <= nx_addr_q;
            lvl_q   <= nx_lvl_q;
            uc_q    <= nx_uc_q;
            state_q <= ST_RD;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o          = (state_q != ST_IDLE);
  assign mem_req_o       = (state_q == ST_RD) || (state_q == ST_WB);
  assign mem_we_o        = (state_q == ST_WB);
  assign mem_addr_o      = addr_q;
  assign mem_uc_o        = uc_q;
  assign mem_wdata_o     = wdata_q;
  assign done_o          = (state_q == ST_FIN);
  assign fault_o         = fault_q;
  assign fault_present_o = fpres_q;
  assign fault_user_o    = user_q;
  assign fault_acc_o     = ((acc_q == ACC_EX) && !nx_en_q) ? ACC_RD : acc_q;
  assign pa_o            = pa_q;
  assign page_2m_o       = big_q;
  assign writable_o      = wr_q;
  assign user_o          = us_q;
  assign global_o        = glb_q;
  assign uncache_o       = ruc_q;
  assign pat_o           = pat_q;
  assign nx_o            = nx_q;

  logic unused_root;
  assign unused_root = ^root_i[3:0];

  // request held steady until acknowledged (R2)
  p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  // writeback targets the address just read (R4)
  p_wb_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_o) |-> (mem_addr_o == $past(mem_addr_o)) && $past(mem_ack_i));

  p_wb_abit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_wdata_o[B_A]);

  // no writeback of a non-present entry (R6)
  p_wb_present_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_o) |-> $past(mem_rdata_i[B_P]));

  p_done_pulse_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_after_ack_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(mem_ack_i));

  // execute reported as read when NX checking is off (R11)
  p_exec_report_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o && !nx_en_q) |-> (fault_acc_o != ACC_EX));
endmodule

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, long_mode = 1'b0, nx_en = 1'b0, user = 1'b0;
  logic [1:0]  acc = 2'd0;
  logic [47:0] va_in = '0;
  logic [51:0] root = '0;
  logic        busy, mem_req, mem_we, mem_uc, done, fault, fpres, fuser;
  logic [51:0] mem_addr, pa;
  logic [63:0] mem_wdata, mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic [1:0]  facc;
  logic        pg2m, wr, us, glb, ucx, pat, nx;

  always #4 clk = ~clk;

  pt_walker dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .long_mode_i(long_mode),
    .nx_en_i(nx_en), .acc_i(acc), .user_i(user), .vaddr_i(va_in), .root_i(root),
    .busy_o(busy), .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_uc_o(mem_uc), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata), .done_o(done), .fault_o(fault),
    .fault_present_o(fpres), .fault_user_o(fuser), .fault_acc_o(facc),
    .pa_o(pa), .page_2m_o(pg2m), .writable_o(wr), .user_o(us),
    .global_o(glb), .uncache_o(ucx), .pat_o(pat), .nx_o(nx)
  );

  typedef struct {bit we; logic [51:0] addr; logic [63:0] data; bit uc;} op_t;

  localparam logic [63:0] F_P = 64'h1, F_W = 64'h2, F_U = 64'h4, F_PCD = 64'h10,
                          F_A = 64'h20, F_PS = 64'h80, F_G = 64'h100,
                          F_B12 = 64'h1000, F_NX = 64'h8000_0000_0000_0000;

  int checks = 0, errors = 0, cyc = 0, lat = 0, wait_cnt = 0, last_ack = 0, op_idx = 0;
  bit done_seen = 0, done_prev = 0, finished = 0;
  logic [63:0] mem [logic [51:0]];
  op_t exp_q[$];
  string first_tag, ex_kind;
  bit ex_fault, ex_fpres, ex_fuser, ex_big, ex_w, ex_u, ex_g, ex_uc, ex_pat, ex_nx, ex_long;
  logic [1:0]  ex_facc;
  logic [51:0] ex_pa;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string rq, input bit ok, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  // behavioural reference of one walk: predicts access stream and result
  task automatic ref_walk(input bit lng, input bit nxe, input logic [1:0] ac, input bit usr,
                          input logic [47:0] va, input logic [51:0] rt);
    logic [51:0] a; logic [63:0] e; logic [8:0] ix;
    int lv; bit c, w, u, x, top, big, leaf;
    w = 0; u = 0; x = 0;
    exp_q.delete();
    ex_fault = 0; ex_fpres = 0; ex_big = 0; ex_pa = '0; ex_pat = 0; ex_g = 0; ex_uc = 0;
    ex_kind = "R9"; ex_long = lng;
    if (lng) begin a = {rt[51:12], 12'h0} + 52'(va[47:39]) * 8; lv = 4; end
    else     begin a = {rt[51:5], 5'h0} + 52'(va[31:30]) * 8; lv = 0; end
    c = rt[4];
    first_tag = lng ? "R1" : "R10";
    forever begin
      e = mem.exists(a) ? mem[a] : 64'h0;
      exp_q.push_back('{1'b0, a, 64'h0, c});
      if (lv == 0) begin
        if (!e[0]) begin ex_fault = 1; ex_fpres = 0; ex_kind = "R6"; break; end
        a = {e[51:12], 12'h0} + 52'(va[29:21]) * 8; c = e[4]; lv = 2;
        continue;
      end
      if (!e[0] || (e[63] && nxe && ac == 2'd2)) begin
        ex_fault = 1; ex_fpres = e[0]; ex_kind = e[0] ? "R7" : "R6"; break;
      end
      top = lng ? (lv == 4) : (lv == 2);
      w = top ? e[1] : (w & e[1]);
      u = top ? e[2] : (u & e[2]);
      x = top ? e[63] : (x | e[63]);
      big = (lv == 2) && e[7];
      leaf = (lv == 1) || big;
      if (!e[5]) exp_q.push_back('{1'b1, a, e | 64'h20, c});
      if (leaf) begin
        ex_big = big;
        ex_pa  = big ? {e[51:21], 21'h0} : {e[51:12], 12'h0};
        ex_pat = (big || lng) ? e[12] : e[7];
        ex_g = e[8]; ex_uc = e[4];
        ex_kind = big ? "R8" : "R9";
        break;
      end
      ix = (lv == 4) ? va[38:30] : (lv == 3) ? va[29:21] : va[20:12];
      a = {e[51:12], 12'h0} + 52'(ix) * 8; c = e[4]; lv--;
    end
    ex_w = w; ex_u = u; ex_nx = x; ex_fuser = usr;
    ex_facc = (ac == 2'd2 && !nxe) ? 2'd0 : ac;
  endtask

  // memory responder and per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_prev) chk("R13", !done, "done one cycle", 64'(done), 64'd0);
      done_prev = done;
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (wait_cnt >= lat) begin
          if (exp_q.size() == 0) begin
            chk(fault ? "R6" : "R4", 1'b0, "unexpected access", 64'(mem_addr), 64'h0);
          end else begin
            op_t o;
            o = exp_q.pop_front();
            chk("R4", mem_we == o.we, "write flag", 64'(mem_we), 64'(o.we));
            chk(op_idx == 0 ? first_tag : "R2", mem_addr == o.addr, "address",
                64'(mem_addr), 64'(o.addr));
            chk("R3", mem_uc == o.uc, "uncacheable", 64'(mem_uc), 64'(o.uc));
            if (o.we) chk("R4", mem_wdata == o.data, "writeback data", mem_wdata, o.data);
          end
          op_idx++;
          if (mem_we) mem[mem_addr] = mem_wdata;
          else mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 64'h0;
          mem_ack = 1'b1; last_ack = cyc; wait_cnt = 0;
        end else wait_cnt++;
      end
      if (done) begin
        done_seen = 1;
        chk("R13", cyc == last_ack + 1, "done timing", 64'(cyc), 64'(last_ack + 1));
        chk(ex_fault ? "R6" : "R4", exp_q.size() == 0, "accesses left", 64'(exp_q.size()), 64'd0);
        chk(ex_fault ? ex_kind : "R9", fault == ex_fault, "fault", 64'(fault), 64'(ex_fault));
        if (ex_fault) begin
          chk(ex_kind, fpres == ex_fpres, "fault present", 64'(fpres), 64'(ex_fpres));
          chk("R11", fuser == ex_fuser, "fault user", 64'(fuser), 64'(ex_fuser));
          chk("R11", facc == ex_facc, "fault access", 64'(facc), 64'(ex_facc));
        end else begin
          chk(ex_kind, pa == ex_pa, "pa", 64'(pa), 64'(ex_pa));
          chk("R8", pg2m == ex_big, "2M flag", 64'(pg2m), 64'(ex_big));
          chk(ex_long ? ex_kind : "R9", pat == ex_pat, "pat", 64'(pat), 64'(ex_pat));
          chk(ex_long ? "R5" : "R10", {wr, us} == {ex_w, ex_u}, "rights",
              64'({wr, us}), 64'({ex_w, ex_u}));
          chk("R12", {glb, ucx, nx} == {ex_g, ex_uc, ex_nx}, "global/uc/nx",
              64'({glb, ucx, nx}), 64'({ex_g, ex_uc, ex_nx}));
        end
      end
    end
  end

  task automatic run_walk(input bit lng, input bit nxe, input logic [1:0] ac, input bit usr,
                          input logic [47:0] va, input logic [51:0] rt, input int lt,
                          input bit glitch);
    int n;
    ref_walk(lng, nxe, ac, usr, va, rt);
    lat = lt; op_idx = 0; done_seen = 0; wait_cnt = 0;
    @(negedge clk);
    long_mode = lng; nx_en = nxe; acc = ac; user = usr; va_in = va; root = rt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (glitch) begin
      // R14: disturb every input mid-walk
      repeat (3) @(negedge clk);
      start = 1'b1; va_in = ~va; long_mode = ~lng; acc = 2'd2; nx_en = 1'b1;
      user = ~usr; root = ~rt;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done_seen && n < 400) begin @(negedge clk); n++; end
    if (!done_seen) chk("R13", 1'b0, "walk watchdog", 64'(n), 64'd0);
    repeat (3) @(negedge clk);
  endtask

  localparam logic [47:0] VA4 = {9'd1, 9'd2, 9'd3, 9'd4, 12'h123};
  localparam logic [47:0] VA3 = {16'h0, 2'd2, 9'd5, 9'd6, 12'h456};

  task automatic build_4k();
    mem.delete();
    mem[52'h100000 + 8]  = 64'h200000 | F_P | F_W | F_U | F_PCD;
    mem[52'h200000 + 16] = 64'h201000 | F_P | F_W | F_U;
    mem[52'h201000 + 24] = 64'h202000 | F_P | F_W | F_U | F_PCD;
    mem[52'h202000 + 32] = 64'h12_3456_7000 | F_P | F_W | F_G | F_PCD;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R13", {busy, mem_req, done} == 3'b000, "reset idle", 64'({busy, mem_req, done}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13", {busy, mem_req, done} == 3'b000, "idle after reset",
        64'({busy, mem_req, done}), 64'd0);

    // R1 R2 R4 R5 R9: four-level 4 KB page, every accessed bit clear
    build_4k();
    run_walk(1, 0, 2'd1, 1, VA4, 52'h100000, 0, 0);

    // R8 R12: four-level 2 MB page, no writebacks, nx carried without checking
    mem.delete();
    mem[52'h100000 + 8]  = 64'h200000 | F_P | F_W | F_U | F_A;
    mem[52'h200000 + 16] = 64'h201000 | F_P | F_W | F_U | F_A | F_NX;
    mem[52'h201000 + 24] = 64'h4000_1000 | F_P | F_W | F_U | F_A | F_PS | F_G;
    run_walk(1, 0, 2'd2, 0, VA4, 52'h100010, 2, 0);

    // R6: not-present pointer entry after a writeback at the top
    mem.delete();
    mem[52'h100000 + 8] = 64'h200000 | F_P | F_W;
    run_walk(1, 1, 2'd1, 0, VA4, 52'h100000, 1, 0);

    // R7: nx fault on a directory entry with accessed clear
    mem.delete();
    mem[52'h100000 + 8]  = 64'h200000 | F_P | F_W | F_U;
    mem[52'h200000 + 16] = 64'h201000 | F_P | F_W | F_U | F_A;
    mem[52'h201000 + 24] = 64'h202000 | F_P | F_W | F_U | F_NX;
    run_walk(1, 1, 2'd2, 1, VA4, 52'h100000, 0, 0);

    // R11: execute fault with nx off is reported as read
    mem.delete();
    mem[52'h100000 + 8]  = 64'h200000 | F_P | F_W | F_U | F_A;
    mem[52'h200000 + 16] = 64'h201000 | F_P | F_W | F_U | F_A;
    mem[52'h201000 + 24] = 64'h202000 | F_P | F_W | F_U | F_A;
    run_walk(1, 0, 2'd2, 1, VA4, 52'h100000, 1, 0);

    // R10 R9: three-level 4 KB, pointer rights ignored, pat from bit 7
    mem.delete();
    mem[52'h300000 + 16] = 64'h500000 | F_P | F_PCD;
    mem[52'h500000 + 40] = 64'h501000 | F_P | F_W | F_U | F_A;
    mem[52'h501000 + 48] = 64'h0abce000 | F_P | F_W | F_U | F_PS | F_PCD;
    run_walk(0, 1, 2'd0, 0, VA3, 52'h300010, 0, 0);

    // R10 R6 R11: three-level pointer not present, execute with nx on
    mem.delete();
    run_walk(0, 1, 2'd2, 1, VA3, 52'h300000, 1, 0);

    // R8 R10: three-level 2 MB page with accessed clear
    mem.delete();
    mem[52'h300000 + 16] = 64'h500000 | F_P | F_A;
    mem[52'h500000 + 40] = 64'h6020_1000 | F_P | F_W | F_PS | F_NX;
    run_walk(0, 0, 2'd1, 0, VA3, 52'h300000, 2, 0);

    // R14: inputs disturbed during the walk
    build_4k();
    run_walk(1, 0, 2'd1, 1, VA4, 52'h100000, 1, 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule